// File: doc/BRIEF.md
# SDRAM command spacing checker

This block sits beside the command bus of a single-data-rate SDRAM and watches every command that goes by. It keeps one down-counter for each spacing rule. A counter starts when the command that limits a later one is seen. A violation is flagged when the limited command arrives while that counter is still running. Spacings quoted in nanoseconds are turned into clock counts at elaboration from the clock-period parameter. Spacings that are quoted in clocks are taken as they are. The read-to-precharge window comes from CAS latency and burst length.

The checker only observes. It drives nothing back into the controller. Each cycle it produces a one-hot-per-rule violation vector and a single summary flag. The flags are meant for a debug monitor or for an interrupt line.

Top module: `sdr_cmd_spacing_chk`

## Requirements
- R1: An active-low reset clears every counter, the open-row state and the registered violation vector. After reset, no command is flagged because of commands seen before the reset.
- R2: The command input `cmd_i` is decoded as: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge of the bank on `bank_i`, 5 burst stop. Codes 6 and 7 are treated as no-op. The violation vector `viol_code_o` is registered: a violation caused by the inputs of one cycle appears in the following cycle and lasts one cycle. `viol_o` is high in exactly those cycles where `viol_code_o` is nonzero.
- R3: A nanosecond minimum becomes N = ceil(ns / T_CK_NS) clocks. For a rule of N clocks, a limited command issued d cycles after the limiting one is flagged when d < N.
- R4: Bit 0 (activate spacing) is set when an activate goes to a different bank than the previous activate, fewer than ceil(RRD_NS/T_CK_NS) cycles after that activate.
- R5: Bit 1 (row-to-column) is set when a read or write goes to a bank fewer than ceil(RCD_NS/T_CK_NS) cycles after that bank's activate. This rule is tracked per bank.
- R6: Bit 2 (precharge recovery) is set when an activate goes to a bank fewer than ceil(RP_NS/T_CK_NS) cycles after that bank's precharge.
- R7: Bit 3 (minimum row open) is set when a precharge goes to a bank fewer than ceil(RAS_NS/T_CK_NS) cycles after that bank's activate.
- R8: Bit 4 (row cycle) is set when an activate goes to a bank fewer than ceil(RC_NS/T_CK_NS) cycles after the previous activate to the same bank.
- R9: Bit 5 (maximum row open) pulses for one cycle when a bank has been open for M = ceil(RAS_MAX_NS/T_CK_NS) cycles and is not precharged in the cycle at distance M. A precharge at distance M or less is legal.
- R10: The rules measured from the last write data-in strobe are: bit 7 for a read or write within CDL_CK cycles, bit 8 for any precharge within RDL_CK cycles, and bit 9 for a burst stop within BDL_CK cycles. A command in the same cycle as the strobe counts as distance 0.
- R11: Bit 6 (column spacing) is set when a read or write follows another read or write by fewer than CCD_CK cycles. With CCD_CK = 1, column commands on consecutive cycles are legal.
- R12: Bit 10 (read to precharge) is set when any precharge follows a read by fewer than CAS_LAT + BURST_LEN - 2 cycles.
- R13: Several rule bits may be set in the same cycle when one command breaks several rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code (see R2) |
| bank_i | input | BANK_W | Bank addressed by activate, read, write or precharge |
| wr_last_i | input | 1 | Strobe marking the last data-in beat of a write burst |
| viol_o | output | 1 | High when any rule bit is set |
| viol_code_o | output | 11 | One bit per rule, bit positions as in R4 to R12 |

## Verification
The bench builds the checker with a 7 ns clock-period parameter, a 700 ns maximum row-open time, CAS latency 2 and burst length 4. With these values the nanosecond rules round up to windows of 2, 3, 3, 6 and 9 clocks, and each one can be hit just inside and just outside its boundary. The maximum-open limit becomes 100 clocks, short enough to drive both a precharge on the last legal cycle and an expiry. The read-to-precharge window of 4 clocks differs from the write-recovery window of 2, so the two rules can be told apart.

// File: rtl/sdr_spacing_pkg.sv
package sdr_spacing_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } sdr_cmd_e;

    localparam int NUM_RULES    = 11;
    localparam int RULE_RRD     = 0;
    localparam int RULE_RCD     = 1;
    localparam int RULE_RP      = 2;
    localparam int RULE_RASMIN  = 3;
    localparam int RULE_RC      = 4;
    localparam int RULE_RASMAX  = 5;
    localparam int RULE_CCD     = 6;
    localparam int RULE_CDL     = 7;
    localparam int RULE_RDL     = 8;
    localparam int RULE_BDL     = 9;
    localparam int RULE_RDPRE   = 10;

    // ceiling division: nanoseconds to whole clocks
    function automatic int ns_to_ck(input int ns, input int tck);
        return (ns + tck - 1) / tck;
    endfunction

    // bits needed to hold values 0 .. n-1 (at least one)
    function automatic int width_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer
    import sdr_spacing_pkg::*;
#(
    parameter int GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int LOADV = (GAP > 0) ? GAP - 1 : 0;
    localparam int W     = width_for(LOADV + 1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = W'(LOADV);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sdr_row_age.sv
module sdr_row_age
    import sdr_spacing_pkg::*;
#(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic expire_o
);

    localparam int W = width_for(LIMIT);

    typedef struct packed {
        logic         open;
        logic [W-1:0] cnt;
    } age_t;

    age_t age_d;
    age_t age_q;

    assign expire_o = age_q.open && (age_q.cnt == '0) && !close_i;

    always_comb begin
        age_d = age_q;
        if (open_i) begin
            age_d.open = 1'b1;
            age_d.cnt  = W'(LIMIT - 1);
        end else if (close_i || expire_o) begin
            age_d.open = 1'b0;
        end else if (age_q.open && (age_q.cnt != '0)) begin
            age_d.cnt = age_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/sdr_cmd_spacing_chk.sv
module sdr_cmd_spacing_chk
    import sdr_spacing_pkg::*;
#(
    parameter int T_CK_NS    = 10,
    parameter int RRD_NS     = 12,
    parameter int RCD_NS     = 16,
    parameter int RP_NS      = 18,
    parameter int RAS_NS     = 42,
    parameter int RC_NS      = 60,
    parameter int RAS_MAX_NS = 100000,
    parameter int CCD_CK     = 1,
    parameter int CDL_CK     = 1,
    parameter int RDL_CK     = 2,
    parameter int BDL_CK     = 1,
    parameter int CAS_LAT    = 3,
    parameter int BURST_LEN  = 4,
    parameter int BANK_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic                 wr_last_i,
    output logic                 viol_o,
    output logic [NUM_RULES-1:0] viol_code_o
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int RRD_CK    = ns_to_ck(RRD_NS, T_CK_NS);
    localparam int RCD_CK    = ns_to_ck(RCD_NS, T_CK_NS);
    localparam int RP_CK     = ns_to_ck(RP_NS, T_CK_NS);
    localparam int RAS_CK    = ns_to_ck(RAS_NS, T_CK_NS);
    localparam int RC_CK     = ns_to_ck(RC_NS, T_CK_NS);
    localparam int RASMAX_CK = ns_to_ck(RAS_MAX_NS, T_CK_NS);
    localparam int RDPRE_CK  = CAS_LAT + BURST_LEN - 2;

    typedef struct packed {
        logic [NUM_RULES-1:0] code;
        logic [BANK_W-1:0]    last_act;
    } chk_state_t;

    chk_state_t st_d;
    chk_state_t st_q;

    logic is_act, is_col, is_rd, is_pre, is_bst;

    assign is_act = (cmd_i == CMD_ACT);
    assign is_rd  = (cmd_i == CMD_RD);
    assign is_col = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
    assign is_pre = (cmd_i == CMD_PRE);
    assign is_bst = (cmd_i == CMD_BST);

    // per-bank windows
    logic [NUM_BANKS-1:0] rcd_busy;
    logic [NUM_BANKS-1:0] rp_busy;
    logic [NUM_BANKS-1:0] ras_busy;
    logic [NUM_BANKS-1:0] rc_busy;
    logic [NUM_BANKS-1:0] age_exp;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank_i == BANK_W'(b));

        sdr_gap_timer #(.GAP(RCD_CK)) u_rcd (
            .clk(clk), .rst_n(rst_n), .load_i(is_act && hit), .busy_o(rcd_busy[b]));
        sdr_gap_timer #(.GAP(RAS_CK)) u_ras (
            .clk(clk), .rst_n(rst_n), .load_i(is_act && hit), .busy_o(ras_busy[b]));
        sdr_gap_timer #(.GAP(RC_CK)) u_rc (
            .clk(clk), .rst_n(rst_n), .load_i(is_act && hit), .busy_o(rc_busy[b]));
        sdr_gap_timer #(.GAP(RP_CK)) u_rp (
            .clk(clk), .rst_n(rst_n), .load_i(is_pre && hit), .busy_o(rp_busy[b]));
        sdr_row_age #(.LIMIT(RASMAX_CK)) u_age (
            .clk(clk), .rst_n(rst_n), .open_i(is_act && hit),
            .close_i(is_pre && hit), .expire_o(age_exp[b]));
    end

    // bank-independent windows
    logic rrd_busy, ccd_busy, cdl_busy, rdl_busy, bdl_busy, rdpre_busy;

    sdr_gap_timer #(.GAP(RRD_CK)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load_i(is_act), .busy_o(rrd_busy));
    sdr_gap_timer #(.GAP(CCD_CK)) u_ccd (
        .clk(clk), .rst_n(rst_n), .load_i(is_col), .busy_o(ccd_busy));
    sdr_gap_timer #(.GAP(CDL_CK)) u_cdl (
        .clk(clk), .rst_n(rst_n), .load_i(wr_last_i), .busy_o(cdl_busy));
    sdr_gap_timer #(.GAP(RDL_CK)) u_rdl (
        .clk(clk), .rst_n(rst_n), .load_i(wr_last_i), .busy_o(rdl_busy));
    sdr_gap_timer #(.GAP(BDL_CK)) u_bdl (
        .clk(clk), .rst_n(rst_n), .load_i(wr_last_i), .busy_o(bdl_busy));
    sdr_gap_timer #(.GAP(RDPRE_CK)) u_rdpre (
        .clk(clk), .rst_n(rst_n), .load_i(is_rd), .busy_o(rdpre_busy));

    // a command in the strobe cycle itself is at distance zero
    logic wl_cdl_now, wl_rdl_now, wl_bdl_now;
    assign wl_cdl_now = wr_last_i && (CDL_CK > 0);
    assign wl_rdl_now = wr_last_i && (RDL_CK > 0);
    assign wl_bdl_now = wr_last_i && (BDL_CK > 0);

    always_comb begin
        st_d      = st_q;
        st_d.code = '0;
        st_d.code[RULE_RRD]    = is_act && rrd_busy && (bank_i != st_q.last_act);
        st_d.code[RULE_RCD]    = is_col && rcd_busy[bank_i];
        st_d.code[RULE_RP]     = is_act && rp_busy[bank_i];
        st_d.code[RULE_RASMIN] = is_pre && ras_busy[bank_i];
        st_d.code[RULE_RC]     = is_act && rc_busy[bank_i];
        st_d.code[RULE_RASMAX] = |age_exp;
        st_d.code[RULE_CCD]    = is_col && ccd_busy;
        st_d.code[RULE_CDL]    = is_col && (cdl_busy || wl_cdl_now);
        st_d.code[RULE_RDL]    = is_pre && (rdl_busy || wl_rdl_now);
        st_d.code[RULE_BDL]    = is_bst && (bdl_busy || wl_bdl_now);
        st_d.code[RULE_RDPRE]  = is_pre && rdpre_busy;
        if (is_act) begin
            st_d.last_act = bank_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_code_o = st_q.code;
    assign viol_o      = |st_q.code;

endmodule

// File: rtl/sdr_cmd_spacing_sva.sv
module sdr_cmd_spacing_sva
    import sdr_spacing_pkg::*;
#(
    parameter int RCD_CK   = 2,
    parameter int RC_CK    = 2,
    parameter int RDPRE_CK = 2,
    parameter int BANK_W   = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_i,
    input logic [BANK_W-1:0]    bank_i,
    input logic                 wr_last_i,
    input logic                 viol_o,
    input logic [NUM_RULES-1:0] viol_code_o
);

    localparam logic [NUM_RULES-1:0] NOT_AGE = ~(NUM_RULES'(1) << RULE_RASMAX);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (viol_code_o == '0) && !viol_o);

    // R2
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP) && !wr_last_i |=> ((viol_code_o & NOT_AGE) == '0));

    if (RC_CK > 1) begin : g_rc
        // R8
        rc_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i == CMD_ACT) && ($past(cmd_i) == CMD_ACT) && $past(rst_n)
            && (bank_i == $past(bank_i)) |=> viol_code_o[RULE_RC]);
    end

    if (RCD_CK > 1) begin : g_rcd
        // R5
        rcd_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && ($past(cmd_i) == CMD_ACT)
            && $past(rst_n) && (bank_i == $past(bank_i)) |=> viol_code_o[RULE_RCD]);
    end

    if (RDPRE_CK > 1) begin : g_rdpre
        // R12
        rd_pre_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i == CMD_PRE) && ($past(cmd_i) == CMD_RD) && $past(rst_n)
            |=> viol_code_o[RULE_RDPRE]);
    end

endmodule

bind sdr_cmd_spacing_chk sdr_cmd_spacing_sva #(
    .RCD_CK  (RCD_CK),
    .RC_CK   (RC_CK),
    .RDPRE_CK(RDPRE_CK),
    .BANK_W  (BANK_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .wr_last_i  (wr_last_i),
    .viol_o     (viol_o),
    .viol_code_o(viol_code_o)
);

// File: tb/sdr_cmd_spacing_chk_tb.sv
module sdr_cmd_spacing_chk_tb;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR  = 3'd3, C_PRE = 3'd4, C_BST = 3'd5;

    localparam logic [10:0] E_0      = 11'h000;
    localparam logic [10:0] E_RRD    = 11'h001;
    localparam logic [10:0] E_RCD    = 11'h002;
    localparam logic [10:0] E_RP     = 11'h004;
    localparam logic [10:0] E_RASMIN = 11'h008;
    localparam logic [10:0] E_RC     = 11'h010;
    localparam logic [10:0] E_RASMAX = 11'h020;
    localparam logic [10:0] E_CDL    = 11'h080;
    localparam logic [10:0] E_RDL    = 11'h100;
    localparam logic [10:0] E_BDL    = 11'h200;
    localparam logic [10:0] E_RDPRE  = 11'h400;

    // windows with T_CK_NS=7: RRD 2, RCD 3, RP 3, RAS 6, RC 9; RASMAX 100; RDPRE 4 (R3)
    localparam int NVEC = 22;
    localparam logic [15:0] TBL [NVEC] = '{
        {C_ACT, 1'b0, 1'b0, E_0},                 // 0
        {C_ACT, 1'b1, 1'b0, E_RRD},               // 1  R4 d=1
        {C_RD,  1'b0, 1'b0, E_RCD},               // 2  R5 d=2
        {C_RD,  1'b0, 1'b0, E_0},                 // 3  R5 d=3 legal, R11 consecutive
        {C_PRE, 1'b0, 1'b0, E_RASMIN | E_RDPRE},  // 4  R7 R12 R13
        {C_NOP, 1'b0, 1'b0, E_0},                 // 5
        {C_ACT, 1'b0, 1'b0, E_RP | E_RC},         // 6  R6 R8 R13
        {C_WR,  1'b1, 1'b0, E_0},                 // 7
        {C_NOP, 1'b0, 1'b1, E_0},                 // 8  strobe
        {C_PRE, 1'b1, 1'b0, E_RDL},               // 9  R10 d=1
        {C_WR,  1'b0, 1'b1, E_CDL},               // 10 R10 same cycle
        {C_BST, 1'b0, 1'b0, E_0},                 // 11 R10 d=1 legal
        {C_BST, 1'b0, 1'b1, E_BDL},               // 12 R10 same cycle
        {C_PRE, 1'b0, 1'b0, E_RDL},               // 13 R10
        {C_NOP, 1'b0, 1'b0, E_0},                 // 14
        {C_NOP, 1'b0, 1'b0, E_0},                 // 15
        {C_ACT, 1'b0, 1'b0, E_0},                 // 16 R6 d=3 legal
        {C_ACT, 1'b1, 1'b0, E_RRD},               // 17 R4
        {C_NOP, 1'b0, 1'b0, E_0},                 // 18
        {C_ACT, 1'b0, 1'b0, E_RC},                // 19 R8 d=3 (R4 d=2 legal)
        {C_RD,  1'b1, 1'b0, E_0},                 // 20 R5 d=3 legal
        {C_RD,  1'b0, 1'b0, E_RCD}                // 21 R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        bank = 1'b0;
    logic        wl = 1'b0;
    logic        viol;
    logic [10:0] code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdr_cmd_spacing_chk #(
        .T_CK_NS   (7),
        .RAS_MAX_NS(700),
        .CAS_LAT   (2),
        .BURST_LEN (4)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .bank_i     (bank),
        .wr_last_i  (wl),
        .viol_o     (viol),
        .viol_code_o(code)
    );

    task automatic chk(input string tag, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic b, input logic w);
        cmd  = c;
        bank = b;
        wl   = w;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd   = C_NOP;
        wl    = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 code in reset", code, E_0);
        chk("R1 flag in reset", {10'b0, viol}, 11'h000);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // table walk: R2 registered code one cycle later, R3 rounding
        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i][15:13], TBL[i][12], TBL[i][11]);
            chk($sformatf("R2 R3 table vector %0d", i), code, TBL[i][10:0]);
            chk($sformatf("R2 flag vector %0d", i), {10'b0, viol},
                {10'b0, TBL[i][10:0] != 11'h000});
        end

        // R9: precharge exactly at the limit is legal
        do_reset();
        step(C_ACT, 1'b0, 1'b0);
        for (int k = 1; k < 100; k++) step(C_NOP, 1'b0, 1'b0);
        step(C_PRE, 1'b0, 1'b0);
        chk("R9 precharge at limit", code, E_0);
        step(C_NOP, 1'b0, 1'b0);
        chk("R9 no late pulse", code, E_0);

        // R9: expiry pulses once
        step(C_ACT, 1'b1, 1'b0);
        for (int k = 1; k < 100; k++) step(C_NOP, 1'b0, 1'b0);
        chk("R9 before limit", code, E_0);
        step(C_NOP, 1'b0, 1'b0);
        chk("R9 expiry", code, E_RASMAX);
        chk("R9 expiry flag", {10'b0, viol}, 11'h001);
        step(C_NOP, 1'b0, 1'b0);
        chk("R9 single pulse", code, E_0);

        // R12 and R7 boundaries
        do_reset();
        step(C_ACT, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_RD,  1'b0, 1'b0);
        chk("R5 read at window", code, E_0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_PRE, 1'b0, 1'b0);
        chk("R12 precharge 3 after read", code, E_RDPRE);
        step(C_ACT, 1'b1, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_RD,  1'b1, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_PRE, 1'b1, 1'b0);
        chk("R12 precharge 4 after read", code, E_0);
        step(C_ACT, 1'b0, 1'b0);
        chk("R6 activate after recovery", code, E_0);
        for (int k = 0; k < 4; k++) step(C_NOP, 1'b0, 1'b0);
        step(C_PRE, 1'b0, 1'b0);
        chk("R7 precharge at 5", code, E_RASMIN);
        step(C_ACT, 1'b0, 1'b0);
        chk("R13 recovery and row cycle", code, E_RP | E_RC);
        step(C_NOP, 1'b0, 1'b0);
        step(C_ACT, 1'b1, 1'b0);
        chk("R4 activate at 2", code, E_0);
        for (int k = 0; k < 5; k++) step(C_NOP, 1'b0, 1'b0);
        step(C_PRE, 1'b1, 1'b0);
        chk("R7 precharge at 6", code, E_0);

        // R1: reset inside a window forgets it
        do_reset();
        step(C_ACT, 1'b0, 1'b0);
        do_reset();
        step(C_ACT, 1'b0, 1'b0);
        chk("R1 window cleared", code, E_0);

        // R11 consecutive column commands, R10 precharge at strobe+2
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_WR, 1'b0, 1'b0);
        chk("R11 first write", code, E_0);
        step(C_WR, 1'b0, 1'b0);
        chk("R11 write after write", code, E_0);
        step(C_RD, 1'b0, 1'b0);
        chk("R11 read after write", code, E_0);
        step(C_NOP, 1'b0, 1'b0);
        step(C_NOP, 1'b0, 1'b1);
        step(C_NOP, 1'b0, 1'b0);
        step(C_PRE, 1'b0, 1'b0);
        chk("R10 precharge 2 after strobe", code, E_0);

        finish_run();
    end

endmodule